// File: doc/BRIEF.md
# Vacuum-Fluorescent Tube Driver Serial Shifter

This block sends one grid's worth of grid and anode bits to an external high-voltage tube driver over three wires: a serial clock, a serial data line and a latch-load line. A start strobe captures a parallel frame of up to 122 bits and a bit count. The block then shifts the bits out at half the system clock rate. It changes data while the serial clock is low, and the external driver samples each bit on the rising edge. After the last bit, the block pulses the latch-load line so that the driver's output latch takes the new pattern.

A one-cycle done pulse tells the multiplex sequencer that the frame is on its way into the latch. The sequencer chooses which grid is sent and handles blanking and intensity. While a frame is in flight, further start requests are dropped, so the sequencer can hold start high and the frames follow one another.

Top module: `vfd_shifter`

## Requirements
- R1: While reset is held, and in the first cycle after it, sclk is 1, and sdo, latch_ld and done are 0.
- R2: A start seen at a clock edge while idle begins a frame. From the next cycle on, each bit takes two system cycles: sclk is 0 in the first and 1 in the second. Between frames, sclk stays at 1.
- R3: Bit k of the frame (frame[k], with k counted from 0) is sent as the k-th bit, so frame[0] goes first. sdo takes a new value only in a cycle where sclk goes from 1 to 0, and it holds that value through the cycle where sclk rises.
- R4: The number of bits sent is bit_count. A bit_count of 0, or of any value above 122, sends 122 bits.
- R5: In the two cycles after the last sclk high cycle, latch_ld is 1 and sclk stays 1. latch_ld is 0 at all other times.
- R6: done is 1 for exactly one cycle, which is the first of the two latch_ld cycles.
- R7: frame and bit_count are sampled only when a start is accepted. A start is not accepted, and has no effect, from the edge that accepts a frame up to and including the edge that drops latch_ld.
- R8: sdo is 0 whenever no bit is being shifted, which includes the latch_ld cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a frame |
| frame | input | MAX_BITS (122) | Parallel frame; bit 0 is sent first |
| bit_count | input | CW (7) | Number of bits to send |
| sclk | output | 1 | Serial clock to the tube driver |
| sdo | output | 1 | Serial data to the tube driver |
| latch_ld | output | 1 | Latch-load; high makes the driver latch transparent |
| done | output | 1 | One-cycle pulse when the last bit has been shifted |

## Verification
Take the clock edge that accepts a start as edge 0, and let m be the bit count in force. After edge 2k, sclk is low and sdo carries bit k. After edge 2k+1, sclk is high. After edge 2m, latch_ld and done rise. After edge 2m+1, only latch_ld stays high. Edge 2m+3 is the first edge that can accept the next start. The bench keeps a counter of elapsed edges and derives the expected value of every output from it, then compares all four outputs at each falling clock edge, half a cycle after the registers update. A separate count of sclk rises is checked against m when done appears.

// File: rtl/vfd_shifter.sv
module vfd_shifter #(
  parameter int MAX_BITS = 122,
  localparam int CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] frame,
  input  logic [CW-1:0]       bit_count,
  output logic                sclk,
  output logic                sdo,
  output logic                latch_ld,
  output logic                done
);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD} state_t;

  state_t              st;
  logic [MAX_BITS-1:0] shreg;
  logic [CW-1:0]       left;
  logic [CW-1:0]       lim;
  logic                ph;

  assign lim = (bit_count == '0 || bit_count > CW'(MAX_BITS)) ? CW'(MAX_BITS) : bit_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      shreg    <= '0;
      left     <= '0;
      ph       <= 1'b0;
      sclk     <= 1'b1;
      sdo      <= 1'b0;
      latch_ld <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            shreg <= frame >> 1;
            sdo   <= frame[0];
            sclk  <= 1'b0;
            left  <= lim - 1'b1;
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!sclk) begin
            sclk <= 1'b1;
          end else if (left == '0) begin
            sdo      <= 1'b0;
            latch_ld <= 1'b1;
            done     <= 1'b1;
            ph       <= 1'b0;
            st       <= S_LOAD;
          end else begin
            sclk  <= 1'b0;
            sdo   <= shreg[0];
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
          end
        end
        S_LOAD: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            latch_ld <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vfd_shifter_chk.sv
module vfd_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdo,
  input logic latch_ld,
  input logic done
);

  assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdo));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(latch_ld));

  assert_load_two_cycles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_ld) |=> latch_ld ##1 !latch_ld);

  assert_load_sclk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ld |-> sclk);

  assert_load_sdo_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ld |-> !sdo);

endmodule

bind vfd_shifter vfd_shifter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .latch_ld(latch_ld), .done(done)
);

// File: tb/vfd_shifter_tb_top.sv
module vfd_shifter_tb_top;
  localparam int NB = 122;
  localparam int CW = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] frame = '0;
  logic [CW-1:0] bit_count = '0;
  logic          sclk, sdo, latch_ld, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  vfd_shifter #(.MAX_BITS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .bit_count(bit_count),
    .sclk(sclk), .sdo(sdo), .latch_ld(latch_ld), .done(done)
  );

  // reference model state
  bit            busy = 1'b0;
  int            t = 0;
  int            m = 0;
  logic [NB-1:0] fr = '0;
  int            rises = 0;
  bit            prev_sclk = 1'b1;

  function automatic int limit(input int bc);
    return (bc == 0 || bc > NB) ? NB : bc;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) busy = 1'b0;
    else if (busy) begin
      t++;
      if (t == 2 * m + 2) busy = 1'b0;
    end else if (start) begin
      busy = 1'b1;
      t = 0;
      m = limit(int'(bit_count));
      fr = frame;
    end
  end

  always @(negedge clk) begin
    bit e_sclk, e_sdo, e_ld, e_done;
    if (rst_n) begin
      e_sclk = 1'b1; e_sdo = 1'b0; e_ld = 1'b0; e_done = 1'b0;
      if (busy) begin
        if (t < 2 * m) begin
          e_sclk = t[0];
          e_sdo  = fr[t / 2];
        end else begin
          e_ld   = 1'b1;
          e_done = (t == 2 * m);
        end
      end
      check(sclk === e_sclk, "R2 sclk", int'(sclk), int'(e_sclk));
      check(sdo === e_sdo, (busy && t < 2 * m) ? "R3 sdo" : "R8 sdo", int'(sdo), int'(e_sdo));
      check(latch_ld === e_ld, "R5 latch_ld", int'(latch_ld), int'(e_ld));
      check(done === e_done, "R6 done", int'(done), int'(e_done));
      if (sclk && !prev_sclk) rises++;
      if (done) begin
        check(rises == m, "R4 bit count", rises, m);
        rises = 0;
      end
      prev_sclk = sclk;
    end
  end

  function automatic logic [NB-1:0] rnd_frame();
    logic [127:0] r;
    r = {$urandom, $urandom, $urandom, $urandom};
    return r[NB-1:0];
  endfunction

  task automatic send(input logic [NB-1:0] f, input int bc);
    @(negedge clk);
    start = 1'b1; frame = f; bit_count = CW'(bc);
    @(negedge clk);
    start = 1'b0;
    repeat (2 * limit(bc) + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(sclk === 1'b1 && sdo === 1'b0 && latch_ld === 1'b0 && done === 1'b0,
          "R1 reset", {sclk, sdo, latch_ld, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1 && sdo === 1'b0 && latch_ld === 1'b0 && done === 1'b0,
          "R1 after reset", {sclk, sdo, latch_ld, done}, 4'b1000);

    send({{(NB-1){1'b0}}, 1'b1}, 1);
    send(122'h2A5, 10);
    send(rnd_frame(), 5);
    send(rnd_frame(), 122);
    // R4: zero and over-range counts give the full length
    send(rnd_frame(), 0);
    send(rnd_frame(), 127);
    send({NB{1'b1}}, 64);

    // R7: start and new inputs during a frame are ignored
    @(negedge clk);
    start = 1'b1; frame = rnd_frame(); bit_count = CW'(6);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    frame = rnd_frame(); bit_count = CW'(20); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;   // lands in the latch window
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy, "R7 single frame", int'(busy), 0);

    // back-to-back frames with start held high
    frame = rnd_frame(); bit_count = CW'(3); start = 1'b1;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule